// File: doc/BRIEF.md
# Register-Direct Two-Operand Integer Executor

This block carries out one two-operand integer instruction at a time against its own bank of eight 32-bit general registers. An upstream decoder presents the primary opcode byte, a flag that says a 0x0F escape byte came before it, and the ModR/M byte, all qualified by a one-cycle valid strobe. The block splits ModR/M into its mode, source-register and destination-register fields. It runs add, subtract, AND, OR, XOR, compare, copy, exchange or signed multiply through one shared datapath. On the same clock edge it writes the result back to the register bank and updates the sign, zero and overflow flags.

Only the register-direct mode is executed. Any other mode, and any opcode outside the supported set, is refused: the block raises an error pulse and changes no state. A side port preloads registers from the rest of the pipeline. A combinational read port exposes any register to the consumers downstream. The registers are numbered 0 to 7 in this order: EAX, ECX, EDX, EBX, ESP, EBP, ESI, EDI.

Top module: `regexec_alu`

## Requirements
- R1: ModR/M is split into mode = bits 7:6, source register index = bits 5:3 and destination register index = bits 2:0. Register index n on the read, load and ModR/M fields addresses the same register n (0 = EAX through 7 = EDI).
- R2: A valid instruction whose mode field is not 3 produces a one-cycle `error` pulse and no `done`, and leaves all registers and flags unchanged.
- R3: Opcode 0x01 writes dst + src into dst. SF takes bit 31 of the result, ZF is set when the result is zero, and OF is set on signed overflow. Example: ModR/M 0xD8 with EAX = 0x10 and EBX = 1 leaves EAX = 0x11.
- R4: Opcode 0x29 writes dst - src into dst and sets SF, ZF and OF (signed overflow) from the difference.
- R5: Opcodes 0x21, 0x09 and 0x31 write dst AND src, dst OR src and dst XOR src into dst. They set SF and ZF from the result and clear OF.
- R6: Opcode 0x39 computes dst - src and writes no register. SF is set when the 32-bit difference is negative, ZF when it is zero, and OF when the true signed difference does not fit in 32 bits.
- R7: Opcode 0x89 copies src into dst and leaves the flags unchanged.
- R8: Opcode 0x87 swaps dst and src; both registers are written on the same edge. The flags are unchanged, and a swap of a register with itself leaves it unchanged.
- R9: With the escape flag set and opcode byte 0xAF, the low 32 bits of the signed product src × dst are written into the source-field register (bits 5:3), not dst. The flags are unchanged.
- R10: An unsupported opcode byte without the escape flag, or any byte other than 0xAF with the escape flag, produces a one-cycle `error` pulse and has no side effect.
- R11: Results, flags and the one-cycle `done` or `error` pulse all appear together in the cycle after the edge that samples `instValid`. `done` and `error` are never high together, and neither is high unless an instruction was presented the cycle before. Back-to-back instructions see each other's results.
- R12: `loadEn` writes `loadData` into register `loadSel` at the next edge when `instValid` is low. It is ignored while `instValid` is high.
- R13: After reset all registers read zero, the three flags are low, and `done` and `error` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instValid | input | 1 | Instruction strobe, one cycle per instruction |
| escPresent | input | 1 | A 0x0F escape byte preceded the opcode |
| opByte | input | 8 | Primary opcode byte |
| modrm | input | 8 | ModR/M byte |
| loadEn | input | 1 | Preload write enable |
| loadSel | input | 3 | Preload register index |
| loadData | input | 32 | Preload value |
| rdSel | input | 3 | Read port register index |
| rdData | output | 32 | Read port value (combinational) |
| flagSign | output | 1 | Sign flag |
| flagZero | output | 1 | Zero flag |
| flagOvf | output | 1 | Overflow flag |
| done | output | 1 | Instruction committed |
| error | output | 1 | Instruction refused |

## Verification
The bench builds the block with its default 32-bit data width, so the concrete operand values of the requirements apply as written. This width brings the signed boundaries within reach: 0x7FFFFFFF + 1, 0x80000000 - 1 and negative products. A scoreboard predicts the flags and the done-or-error pulse of each instruction. The register bank is then compared through the read port after every instruction, including the refused ones, back-to-back issues and a preload that collides with an instruction.

// File: rtl/regexec_pkg.sv
package regexec_pkg;

  localparam int REG_CNT = 8;
  localparam int IDX_W   = $clog2(REG_CNT);

  localparam logic [7:0] OPC_ADD  = 8'h01;
  localparam logic [7:0] OPC_OR   = 8'h09;
  localparam logic [7:0] OPC_AND  = 8'h21;
  localparam logic [7:0] OPC_SUB  = 8'h29;
  localparam logic [7:0] OPC_XOR  = 8'h31;
  localparam logic [7:0] OPC_CMP  = 8'h39;
  localparam logic [7:0] OPC_XCHG = 8'h87;
  localparam logic [7:0] OPC_MOV  = 8'h89;
  localparam logic [7:0] OPC_IMUL = 8'hAF;  // only after the escape byte

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR, ALU_PASS, ALU_MUL
  } aluOp_e;

  typedef enum logic [1:0] {
    FLG_KEEP, FLG_ARITH, FLG_LOGIC
  } flagMode_e;

  typedef struct packed {
    logic      inst;       // an instruction occupies this cycle
    logic      commit;     // accepted instruction commits at this edge
    aluOp_e    aluOp;
    flagMode_e flagMode;
    logic      wrRm;       // write ALU result to destination field register
    logic      wrReg;      // write to source field register
    logic      regFromRm;  // source field register takes old destination value
  } ctrlStrobe_t;

endpackage

// File: rtl/regexec_ctrl.sv
module regexec_ctrl
  import regexec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              instValid,
  input  logic              escPresent,
  input  logic [7:0]        opByte,
  input  logic [7:0]        modrm,
  output ctrlStrobe_t       strobe,
  output logic [IDX_W-1:0]  rmIdx,
  output logic [IDX_W-1:0]  regIdx,
  output logic              done,
  output logic              error
);

  logic      legal;
  logic      modOk;
  logic      accept;
  aluOp_e    decOp;
  flagMode_e decFlags;
  logic      decWrRm;
  logic      decWrReg;
  logic      decFromRm;
  logic      doneQ;
  logic      errorQ;

  assign modOk  = (modrm[7:6] == 2'b11);
  assign rmIdx  = modrm[IDX_W-1:0];
  assign regIdx = modrm[3 +: IDX_W];

  always_comb begin
    legal     = 1'b0;
    decOp     = ALU_PASS;
    decFlags  = FLG_KEEP;
    decWrRm   = 1'b0;
    decWrReg  = 1'b0;
    decFromRm = 1'b0;
    if (escPresent) begin
      if (opByte == OPC_IMUL) begin
        legal    = 1'b1;
        decOp    = ALU_MUL;
        decWrReg = 1'b1;
      end
    end else begin
      case (opByte)
        OPC_ADD:  begin legal = 1'b1; decOp = ALU_ADD; decFlags = FLG_ARITH; decWrRm = 1'b1; end
        OPC_SUB:  begin legal = 1'b1; decOp = ALU_SUB; decFlags = FLG_ARITH; decWrRm = 1'b1; end
        OPC_AND:  begin legal = 1'b1; decOp = ALU_AND; decFlags = FLG_LOGIC; decWrRm = 1'b1; end
        OPC_OR:   begin legal = 1'b1; decOp = ALU_OR;  decFlags = FLG_LOGIC; decWrRm = 1'b1; end
        OPC_XOR:  begin legal = 1'b1; decOp = ALU_XOR; decFlags = FLG_LOGIC; decWrRm = 1'b1; end
        OPC_CMP:  begin legal = 1'b1; decOp = ALU_SUB; decFlags = FLG_ARITH; end
        OPC_MOV:  begin legal = 1'b1; decOp = ALU_PASS; decWrRm = 1'b1; end
        OPC_XCHG: begin
          legal     = 1'b1;
          decOp     = ALU_PASS;
          decWrRm   = 1'b1;
          decWrReg  = 1'b1;
          decFromRm = 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign accept = instValid && legal && modOk;

  always_comb begin
    strobe.inst      = instValid;
    strobe.commit    = accept;
    strobe.aluOp     = decOp;
    strobe.flagMode  = accept ? decFlags : FLG_KEEP;
    strobe.wrRm      = accept && decWrRm;
    strobe.wrReg     = accept && decWrReg;
    strobe.regFromRm = decFromRm;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      doneQ  <= 1'b0;
      errorQ <= 1'b0;
    end else begin
      doneQ  <= accept;
      errorQ <= instValid && !accept;
    end
  end

  assign done  = doneQ;
  assign error = errorQ;

  // R2: a non-direct mode is refused on the next cycle
  assert_bad_mode_refused_R2: assert property (@(posedge clk) disable iff (!rst_n)
    instValid && !modOk |=> error && !done);

  // R10: an unknown opcode is refused on the next cycle
  assert_bad_opcode_refused_R10: assert property (@(posedge clk) disable iff (!rst_n)
    instValid && !legal |=> error && !done);

  // R11: outcome pulses are exclusive and only follow an instruction
  assert_pulse_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, error}));
  assert_no_spurious_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !instValid |=> !done && !error);

endmodule

// File: rtl/regexec_datapath.sv
module regexec_datapath
  import regexec_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrlStrobe_t       strobe,
  input  logic [IDX_W-1:0]  rmIdx,
  input  logic [IDX_W-1:0]  regIdx,
  input  logic              loadEn,
  input  logic [IDX_W-1:0]  loadSel,
  input  logic [DATA_W-1:0] loadData,
  input  logic [IDX_W-1:0]  rdSel,
  output logic [DATA_W-1:0] rdData,
  output logic              sf,
  output logic              zf,
  output logic              of
);

  localparam int PROD_W = 2 * DATA_W;

  logic [REG_CNT-1:0][DATA_W-1:0] regs;
  logic [DATA_W-1:0] rmVal;
  logic [DATA_W-1:0] regVal;
  logic [DATA_W-1:0] sumVal;
  logic [DATA_W-1:0] diffVal;
  logic signed [PROD_W-1:0] prodFull;
  logic [DATA_W-1:0] aluRes;
  logic              aluOvf;
  logic              sfQ, zfQ, ofQ;

  assign rmVal   = regs[rmIdx];
  assign regVal  = regs[regIdx];
  assign rdData  = regs[rdSel];

  assign sumVal   = rmVal + regVal;
  assign diffVal  = rmVal - regVal;
  assign prodFull = PROD_W'($signed(rmVal)) * PROD_W'($signed(regVal));

  always_comb begin
    aluRes = regVal;
    aluOvf = 1'b0;
    case (strobe.aluOp)
      ALU_ADD: begin
        aluRes = sumVal;
        aluOvf = (rmVal[DATA_W-1] == regVal[DATA_W-1]) && (sumVal[DATA_W-1] != rmVal[DATA_W-1]);
      end
      ALU_SUB: begin
        aluRes = diffVal;
        aluOvf = (rmVal[DATA_W-1] != regVal[DATA_W-1]) && (diffVal[DATA_W-1] != rmVal[DATA_W-1]);
      end
      ALU_AND:  aluRes = rmVal & regVal;
      ALU_OR:   aluRes = rmVal | regVal;
      ALU_XOR:  aluRes = rmVal ^ regVal;
      ALU_MUL:  aluRes = prodFull[DATA_W-1:0];
      default:  aluRes = regVal;
    endcase
  end

  // register bank: both writes of an exchange land on the same edge
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      regs <= '0;
    end else if (strobe.commit) begin
      if (strobe.wrRm)  regs[rmIdx]  <= aluRes;
      if (strobe.wrReg) regs[regIdx] <= strobe.regFromRm ? rmVal : aluRes;
    end else if (loadEn && !strobe.inst) begin
      regs[loadSel] <= loadData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sfQ <= 1'b0;
      zfQ <= 1'b0;
      ofQ <= 1'b0;
    end else if (strobe.flagMode != FLG_KEEP) begin
      sfQ <= aluRes[DATA_W-1];
      zfQ <= (aluRes == '0);
      ofQ <= (strobe.flagMode == FLG_ARITH) ? aluOvf : 1'b0;
    end
  end

  assign sf = sfQ;
  assign zf = zfQ;
  assign of = ofQ;

  // R6: without a write or a preload the bank holds its contents
  assert_bank_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.wrRm && !strobe.wrReg && !(loadEn && !strobe.inst) |=> $stable(regs));

  // R8: exchange moves each old value into the other register
  assert_swap_both_R8: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.wrRm && strobe.wrReg && strobe.regFromRm && (rmIdx != regIdx) |=>
      (regs[$past(rmIdx)] == $past(regVal)) && (regs[$past(regIdx)] == $past(rmVal)));

  // R5: bitwise operations leave overflow clear
  assert_logic_clears_of_R5: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.flagMode == FLG_LOGIC |=> !of);

  // R7: copy, exchange and multiply keep the flags
  assert_keep_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.commit && strobe.flagMode == FLG_KEEP |=> $stable({sf, zf, of}));

endmodule

// File: rtl/regexec_alu.sv
module regexec_alu
  import regexec_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              instValid,
  input  logic              escPresent,
  input  logic [7:0]        opByte,
  input  logic [7:0]        modrm,
  input  logic              loadEn,
  input  logic [IDX_W-1:0]  loadSel,
  input  logic [DATA_W-1:0] loadData,
  input  logic [IDX_W-1:0]  rdSel,
  output logic [DATA_W-1:0] rdData,
  output logic              flagSign,
  output logic              flagZero,
  output logic              flagOvf,
  output logic              done,
  output logic              error
);

  ctrlStrobe_t      strobe;
  logic [IDX_W-1:0] rmIdx;
  logic [IDX_W-1:0] regIdx;

  regexec_ctrl ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .instValid  (instValid),
    .escPresent (escPresent),
    .opByte     (opByte),
    .modrm      (modrm),
    .strobe     (strobe),
    .rmIdx      (rmIdx),
    .regIdx     (regIdx),
    .done       (done),
    .error      (error)
  );

  regexec_datapath #(.DATA_W(DATA_W)) dp_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (strobe),
    .rmIdx    (rmIdx),
    .regIdx   (regIdx),
    .loadEn   (loadEn),
    .loadSel  (loadSel),
    .loadData (loadData),
    .rdSel    (rdSel),
    .rdData   (rdData),
    .sf       (flagSign),
    .zf       (flagZero),
    .of       (flagOvf)
  );

endmodule

// File: tb/regexec_alu_tb.sv
module regexec_alu_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instValid = 1'b0;
  logic        escPresent = 1'b0;
  logic [7:0]  opByte = '0;
  logic [7:0]  modrm = '0;
  logic        loadEn = 1'b0;
  logic [2:0]  loadSel = '0;
  logic [31:0] loadData = '0;
  logic [2:0]  rdSel = '0;
  logic [31:0] rdData;
  logic        flagSign, flagZero, flagOvf, done, error;

  regexec_alu dut_i (.*);

  always #10 clk = ~clk;  // 50 MHz

  typedef struct {
    string tag;
    int    due;
    bit    expDone;
    bit    expErr;
    bit    sf, zf, of;
  } sbItem_t;

  sbItem_t     sbQ[$];
  int          cyc = 0;
  int          checks = 0;
  int          fails = 0;
  logic [31:0] mreg [8];
  bit          mSf = 0, mZf = 0, mOf = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // monitor: pops predicted outcomes and compares them
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      if (sbQ.size() != 0 && sbQ[0].due == cyc) begin
        sbItem_t it;
        it = sbQ.pop_front();
        check(done == it.expDone && error == it.expErr, it.tag, "done/error",
              {30'd0, done, error}, {30'd0, it.expDone, it.expErr});
        check({flagSign, flagZero, flagOvf} == {it.sf, it.zf, it.of}, it.tag, "flags SZO",
              {29'd0, flagSign, flagZero, flagOvf}, {29'd0, it.sf, it.zf, it.of});
      end else if (done || error) begin
        check(1'b0, "R11", "unexpected pulse", {30'd0, done, error}, 32'd0);
      end
    end
  end

  // driver: present one instruction and predict its outcome
  task automatic issue(string tag, bit esc, logic [7:0] op, logic [7:0] mr, bit withLoad = 0);
    logic [2:0]  s, d;
    logic [31:0] a, b, r;
    bit          ok;
    sbItem_t     it;
    @(negedge clk);
    instValid = 1'b1; escPresent = esc; opByte = op; modrm = mr;
    loadEn = withLoad; loadSel = 3'd6; loadData = 32'hDEAD_BEEF;
    s = mr[5:3]; d = mr[2:0];
    a = mreg[d]; b = mreg[s];
    ok = (mr[7:6] == 2'b11);
    if (ok) begin
      if (esc) begin
        if (op == 8'hAF) mreg[s] = 32'(longint'($signed(a)) * longint'($signed(b)));
        else ok = 0;
      end else begin
        case (op)
          8'h01: begin r = a + b; mreg[d] = r; mSf = r[31]; mZf = (r == 0);
                   mOf = (a[31] == b[31]) && (r[31] != a[31]); end
          8'h29, 8'h39: begin
                   r = a - b; if (op == 8'h29) mreg[d] = r;
                   mSf = r[31]; mZf = (r == 0);
                   mOf = (longint'($signed(a)) - longint'($signed(b))) != longint'($signed(r)); end
          8'h21, 8'h09, 8'h31: begin
                   r = (op == 8'h21) ? (a & b) : (op == 8'h09) ? (a | b) : (a ^ b);
                   mreg[d] = r; mSf = r[31]; mZf = (r == 0); mOf = 0; end
          8'h89: mreg[d] = b;
          8'h87: begin mreg[d] = b; mreg[s] = a; end
          default: ok = 0;
        endcase
      end
    end
    it.tag = tag; it.due = cyc + 1; it.expDone = ok; it.expErr = !ok;
    it.sf = mSf; it.zf = mZf; it.of = mOf;
    sbQ.push_back(it);
  endtask

  task automatic idle();
    @(negedge clk);
    instValid = 1'b0; escPresent = 1'b0; loadEn = 1'b0;
  endtask

  task automatic load(logic [2:0] idx, logic [31:0] val);
    @(negedge clk);
    instValid = 1'b0; loadEn = 1'b1; loadSel = idx; loadData = val;
    mreg[idx] = val;
    @(negedge clk);
    loadEn = 1'b0;
  endtask

  task automatic checkRegs(string tag);
    #3;
    for (int i = 0; i < 8; i++) begin
      rdSel = 3'(i);
      #1;
      check(rdData == mreg[i], tag, $sformatf("reg %0d", i), rdData, mreg[i]);
    end
  endtask

  // single instruction then idle, then compare the bank
  task automatic run1(string tag, bit esc, logic [7:0] op, logic [7:0] mr);
    issue(tag, esc, op, mr);
    idle();
    checkRegs(tag);
  endtask

  initial begin
    #(20 * 20000);
    check(1'b0, "WDOG", "watchdog expired", 32'd0, 32'd1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) mreg[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R13: reset state
    check(!done && !error, "R13", "done/error after reset", {30'd0, done, error}, 32'd0);
    check({flagSign, flagZero, flagOvf} == 3'b000, "R13", "flags after reset",
          {29'd0, flagSign, flagZero, flagOvf}, 32'd0);
    checkRegs("R13");

    // R12, R1: preload through side port, indices line up with ModR/M fields
    load(3'd0, 32'h10);
    load(3'd3, 32'h1);
    checkRegs("R12");

    // R3 worked example: 0xD8 = mode 3, src EBX(3), dst EAX(0)
    run1("R3", 0, 8'h01, 8'hD8);
    check(mreg[0] == 32'h11, "R3", "model EAX", mreg[0], 32'h11);
    // R3 signed overflow
    load(3'd1, 32'h7FFF_FFFF); load(3'd2, 32'h1);
    run1("R3", 0, 8'h01, 8'hD1);  // ECX += EDX
    // R4 subtract overflow and zero result
    load(3'd4, 32'h8000_0000);
    run1("R4", 0, 8'h29, 8'hD4);  // ESP -= EDX
    load(3'd5, 32'h55);  load(3'd7, 32'h55);
    run1("R4", 0, 8'h29, 8'hFD);  // EBP -= EDI -> 0

    // R5 bitwise ops
    load(3'd0, 32'h0A0B_0C0D); load(3'd3, 32'h0000_00FF);
    run1("R5", 0, 8'h21, 8'hD8);
    load(3'd0, 32'h0A0B_0C0D); load(3'd3, 32'hA0B0_C0D0);
    run1("R5", 0, 8'h09, 8'hD8);
    load(3'd3, 32'hAABB_C0D0);
    run1("R5", 0, 8'h31, 8'hD8);
    // R5: OF cleared after an overflowing add
    load(3'd1, 32'h7FFF_FFFF); load(3'd2, 32'h1);
    run1("R3", 0, 8'h01, 8'hD1);
    run1("R5", 0, 8'h31, 8'hD1);

    // R6 compare examples
    load(3'd0, 32'h0A0B_0C0D); load(3'd3, 32'h0A0B_0C07);
    run1("R6", 0, 8'h39, 8'hD8);
    load(3'd0, 32'h0A0B_0C07); load(3'd3, 32'h0A0B_0C0D);
    run1("R6", 0, 8'h39, 8'hD8);
    run1("R6", 0, 8'h39, 8'hC0);  // equal: EAX vs EAX
    load(3'd4, 32'h8000_0000); load(3'd2, 32'h1);
    run1("R6", 0, 8'h39, 8'hD4);  // overflow, no writeback

    // R7 copy, flags kept
    load(3'd3, 32'hAF);
    run1("R7", 0, 8'h89, 8'hD8);
    // R8 exchange and self-exchange
    load(3'd0, 32'h2E);
    run1("R8", 0, 8'h87, 8'hD8);
    run1("R8", 0, 8'h87, 8'hF6);  // ESI with ESI
    // R9 signed multiply into the source-field register
    load(3'd0, 32'hFFFF_FFFD); load(3'd3, 32'h5);
    run1("R9", 1, 8'hAF, 8'hD8);
    load(3'd0, 32'h4); load(3'd1, 32'h3);
    run1("R9", 1, 8'hAF, 8'hC8);

    // R2 non-direct modes refused
    run1("R2", 0, 8'h01, 8'h18);
    run1("R2", 0, 8'h87, 8'h98);
    run1("R2", 1, 8'hAF, 8'h58);
    // R10 unsupported opcodes refused
    run1("R10", 0, 8'hFF, 8'hC0);
    run1("R10", 1, 8'h01, 8'hD8);
    run1("R10", 0, 8'hAF, 8'hD8);

    // R11 back-to-back: second instruction sees first result
    load(3'd0, 32'h100); load(3'd3, 32'h3);
    issue("R11", 0, 8'h01, 8'hD8);
    issue("R11", 0, 8'h01, 8'hC3);  // EBX += EAX (new)
    issue("R11", 0, 8'h01, 8'h18);  // refused between
    issue("R11", 0, 8'h29, 8'hD8);
    idle();
    checkRegs("R11");

    // R12 preload ignored during an instruction
    issue("R12", 0, 8'h89, 8'hC8);
    idle();
    checkRegs("R12");
    issue("R12", 0, 8'hFF, 8'hC0, 1);  // refused instruction, load still ignored
    idle();
    checkRegs("R12");

    repeat (3) @(negedge clk);
    check(sbQ.size() == 0, "R11", "outstanding predictions", sbQ.size(), 32'd0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule